// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is a word-addressed on-chip scratchpad built from 16 single-port banks, each 32 bits wide. A caller presents a 32-lane vector request: one word address per lane, a per-lane enable, one write-data word per lane, and a single read/write flag for the whole vector. The block services every enabled lane and then pulses `done`. A read request returns one word per lane. A write request stores one word per lane.

The bank of a word is selected by the low four bits of its address. A bank can perform only one 32-bit access per two-clock slot. The request is split into a lower and an upper group of 16 lanes, and the upper group is processed only after the lower group has finished. Lanes are compared for conflicts only within their own group. In each slot, every bank serves the lowest-numbered lane that is still waiting for it. The latency of a request therefore follows directly from its address pattern. Lanes that target the same address are not merged: each one costs its own slot.

The caller observes the cost of a request through `slot_count`, the number of slots the last request used. This makes the block suitable for measuring how an access pattern behaves against the bank structure.

Top module: `bsp_top`

## Requirements
- R1: Word address A is stored in bank A mod 16, at row A div 16. A word written to address A is returned by every later read of address A until A is written again.
- R2: A request is accepted on a rising edge where `req_valid` is high and `busy` is low. `done` is high for exactly one cycle, starting 2*S rising edges after the accepting edge, where S is the total slot count. `busy` is high from the accepting edge until `done` rises, and `busy` and `done` are never high together.
- R3: Within one 16-lane group, the slots used equal the largest number of enabled lanes that share a bank. For example, lanes reading address 2*lane+1 need 2 slots per group, and 16 lanes of one group reading a single address need 16 slots.
- R4: Lanes 0..15 form the lower group and lanes 16..31 form the upper group. A lane in one group never conflicts with a lane in the other group. S is the sum of the two group counts.
- R5: `slot_count` is 0 after reset. It equals S from the cycle `done` is high until the next request is accepted.
- R6: A disabled lane takes no slot, and its read-data word keeps its previous value. A request with no enabled lane raises `done` one cycle after acceptance, with `slot_count` equal to 0.
- R7: When several lanes of a write request target the same address, the highest-numbered of those lanes leaves its data in memory. This holds both within a group and across the two groups.
- R8: For an enabled lane g of a read request, `rd_data[32*g +: 32]` holds the word at that lane's address by the time `done` is high. A write request leaves `rd_data` unchanged.
- R9: `req_valid` is ignored while `busy` is high. It does not change memory, the slot count or the completion time of the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Presents a request; it is taken when `busy` is low |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_lane_en | input | 32 | Per-lane enable, bit g for lane g |
| req_addr | input | 256 | Word address per lane, lane g at bits [8*g +: 8] |
| req_wdata | input | 1024 | Write data per lane, lane g at bits [32*g +: 32] |
| busy | output | 1 | A request is being serviced |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 1024 | Read data per lane, lane g at bits [32*g +: 32] |
| slot_count | output | 6 | Slots used by the last request |

## Verification
`done` is due exactly 2*S rising edges after the accepting edge. S comes from a per-group bank-occupancy count computed in the bench, so a request with no enabled lane completes after one edge. The bench drives every input on a falling edge. After acceptance it samples `done` on each falling edge and counts the rising edges in between, so the measured latency must equal 2*S and not merely arrive eventually. `slot_count` and `rd_data` are compared in the same falling-edge sample in which `done` is first seen high. The expected words come from a bench memory model that applies writes in ascending lane order.

// File: rtl/bsp_pkg.sv
// Package: shared defaults and the controller state type for the banked
// scratchpad. Assumes the lane count is twice the group size.
package bsp_pkg;
    localparam int LANES_DEF  = 32;
    localparam int BANKS_DEF  = 16;
    localparam int WORD_W_DEF = 32;
    localparam int ADDR_W_DEF = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bsp_state_e;
endpackage

// File: rtl/bsp_slot_pick.sv
// Module: slot picker. For one group of lanes it grants every pending lane
// that is the lowest-numbered pending lane for its bank. Assumes the bank
// index of each lane is supplied packed, lane l at [l*BW +: BW].
module bsp_slot_pick #(
    parameter int N  = 16,
    parameter int BW = 4
) (
    input  logic [N-1:0]    pend,
    input  logic [N*BW-1:0] bank_flat,
    output logic [N-1:0]    grant
);
    // Grant a lane unless a lower pending lane wants the same bank.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            grant[i] = pend[i];
            for (int j = 0; j < N; j++) begin
                if (j < i && pend[j] && bank_flat[j*BW +: BW] == bank_flat[i*BW +: BW]) begin
                    grant[i] = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/bsp_bank_route.sv
// Module: bank router. For one bank it finds the granted lane of the
// current group that targets this bank. Assumes the picker grants at most
// one lane per bank.
module bsp_bank_route #(
    parameter int N       = 16,
    parameter int BW      = 4,
    parameter int BANK_ID = 0,
    localparam int SEL_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    grant,
    input  logic [N*BW-1:0] bank_flat,
    output logic            hit,
    output logic [SEL_W-1:0] sel
);
    // Scan the group for the lane granted to this bank.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int l = 0; l < N; l++) begin
            if (grant[l] && bank_flat[l*BW +: BW] == BW'(BANK_ID)) begin
                hit = 1'b1;
                sel = SEL_W'(l);
            end
        end
    end
endmodule

// File: rtl/bsp_bank.sv
// Module: one single-port bank with a combinational read and a clocked
// write. Assumes the controller issues at most one access per slot. The
// contents are not reset.
module bsp_bank #(
    parameter int WORD_W = 32,
    parameter int ROW_W  = 4,
    localparam int ROWS  = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [ROWS];

    // Store the write word at the end of the slot.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[row] <= wdata;
        end
    end

    // Present the addressed row for capture at the slot edge.
    assign rdata = mem[row];
endmodule

// File: rtl/bsp_top.sv
// Module: banked scratchpad conflict serializer. It latches a vector
// request and services the lower lane group, then the upper group. Each
// slot lasts two clocks, and in each slot every bank serves its
// lowest-numbered pending lane. Assumes LANES is even and the bank count is
// a power of two that is smaller than the address space.
module bsp_top #(
    parameter int LANES  = bsp_pkg::LANES_DEF,
    parameter int BANKS  = bsp_pkg::BANKS_DEF,
    parameter int WORD_W = bsp_pkg::WORD_W_DEF,
    parameter int ADDR_W = bsp_pkg::ADDR_W_DEF,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [LANES-1:0]         req_lane_en,
    input  logic [LANES*ADDR_W-1:0]  req_addr,
    input  logic [LANES*WORD_W-1:0]  req_wdata,
    output logic                     busy,
    output logic                     done,
    output logic [LANES*WORD_W-1:0]  rd_data,
    output logic [CNT_W-1:0]         slot_count
);
    import bsp_pkg::*;

    localparam int HALF   = LANES / 2;
    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam int SEL_W  = (HALF > 1) ? $clog2(HALF) : 1;

    bsp_state_e           state_q;
    logic                 phase_q;
    logic                 write_q;
    logic                 done_q;
    logic [LANES-1:0]     pend_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [ADDR_W-1:0]    addr_q  [LANES];
    logic [WORD_W-1:0]    wdata_q [LANES];
    logic [LANES*WORD_W-1:0] rd_q;

    logic                 upper_sel;
    int unsigned          base;
    logic [HALF-1:0]      half_pend;
    logic [HALF*BANK_W-1:0] half_bank;
    logic [HALF-1:0]      grant;
    logic [LANES-1:0]     grant_full;
    logic [LANES-1:0]     pend_next;
    logic                 slot_fire;

    logic                 bank_hit [BANKS];
    logic [SEL_W-1:0]     bank_sel [BANKS];
    logic [WORD_W-1:0]    bank_rd  [BANKS];

    // Choose the active group: the lower group until it has no pending lane.
    always_comb begin
        upper_sel = ~|pend_q[HALF-1:0];
        base      = upper_sel ? HALF : 0;
        half_pend = upper_sel ? pend_q[LANES-1:HALF] : pend_q[HALF-1:0];
        for (int l = 0; l < HALF; l++) begin
            half_bank[l*BANK_W +: BANK_W] = addr_q[base + l][BANK_W-1:0];
        end
    end

    bsp_slot_pick #(
        .N  (HALF),
        .BW (BANK_W)
    ) u_pick (
        .pend      (half_pend),
        .bank_flat (half_bank),
        .grant     (grant)
    );

    // Widen the group grant to the full lane vector and retire those lanes.
    always_comb begin
        grant_full = upper_sel ? {grant, {HALF{1'b0}}} : {{HALF{1'b0}}, grant};
        pend_next  = pend_q & ~grant_full;
        slot_fire  = (state_q == ST_RUN) && phase_q;
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [ROW_W-1:0]  row;
        logic [WORD_W-1:0] wd;

        bsp_bank_route #(
            .N       (HALF),
            .BW      (BANK_W),
            .BANK_ID (b)
        ) u_route (
            .grant     (grant),
            .bank_flat (half_bank),
            .hit       (bank_hit[b]),
            .sel       (bank_sel[b])
        );

        // Fetch the row and write word of the lane granted to this bank.
        always_comb begin
            row = addr_q[base + int'(bank_sel[b])][ADDR_W-1:BANK_W];
            wd  = wdata_q[base + int'(bank_sel[b])];
        end

        bsp_bank #(
            .WORD_W (WORD_W),
            .ROW_W  (ROW_W)
        ) u_bank (
            .clk   (clk),
            .we    (slot_fire && write_q && bank_hit[b]),
            .row   (row),
            .wdata (wd),
            .rdata (bank_rd[b])
        );
    end

    // Sequence the request: accept it, then count two-clock slots to completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= 1'b0;
            write_q <= 1'b0;
            done_q  <= 1'b0;
            pend_q  <= '0;
            cnt_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        write_q <= req_write;
                        cnt_q   <= '0;
                        phase_q <= 1'b0;
                        pend_q  <= req_lane_en;
                        if (|req_lane_en) begin
                            state_q <= ST_RUN;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    phase_q <= ~phase_q;
                    if (phase_q) begin
                        pend_q <= pend_next;
                        cnt_q  <= cnt_q + 1'b1;
                        if (pend_next == '0) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the per-lane addresses and write data when a request is taken.
    always_ff @(posedge clk) begin
        if (state_q == ST_IDLE && req_valid) begin
            for (int g = 0; g < LANES; g++) begin
                addr_q[g]  <= req_addr[g*ADDR_W +: ADDR_W];
                wdata_q[g] <= req_wdata[g*WORD_W +: WORD_W];
            end
        end
    end

    // Capture the read word of every lane served in a read slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            for (int l = 0; l < HALF; l++) begin
                if (slot_fire && !write_q && grant[l]) begin
                    rd_q[(base + l)*WORD_W +: WORD_W] <= bank_rd[half_bank[l*BANK_W +: BANK_W]];
                end
            end
        end
    end

    assign busy       = (state_q == ST_RUN);
    assign done       = done_q;
    assign rd_data    = rd_q;
    assign slot_count = cnt_q;
endmodule

// File: rtl/bsp_checker.sv
// Module: protocol checker for the scratchpad, bound to bsp_top. It only
// observes the top-level handshake and the slot counter.
module bsp_checker #(
    parameter int LANES = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [LANES-1:0] req_lane_en,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] slot_count
);
    // R2: the completion pulse lasts one cycle.
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: busy and done never overlap.
    assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: an accepted request with an enabled lane makes the block busy.
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && |req_lane_en) |=> busy);

    // R6: an empty request completes after one edge with zero slots.
    assert_empty_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_lane_en == '0) |=> (done && !busy && slot_count == '0));

    // R3: no request uses more slots than it has lanes.
    assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_count <= CNT_W'(LANES));

    // R5: the slot count never drops while a request is in progress.
    assert_count_mono_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (slot_count >= $past(slot_count)));
endmodule

bind bsp_top bsp_checker #(
    .LANES (LANES),
    .CNT_W (CNT_W)
) u_bsp_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_lane_en (req_lane_en),
    .busy        (busy),
    .done        (done),
    .slot_count  (slot_count)
);

// File: tb/bsp_top_bench.sv
// Directed bench for bsp_top: one task per scenario, each checking its results.
module bsp_top_bench;
    localparam int LANES = 32;
    localparam int AW    = 8;
    localparam int WW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [LANES-1:0]    req_lane_en = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [LANES*WW-1:0] req_wdata = '0;
    logic busy, done;
    logic [LANES*WW-1:0] rd_data;
    logic [5:0] slot_count;

    int checks = 0;
    int failures = 0;

    logic [7:0]    t_addr [LANES];
    logic [WW-1:0] t_wd   [LANES];
    logic [LANES-1:0] t_en;
    logic [WW-1:0] mdl [256];

    always #4 clk = ~clk;

    bsp_top u_bsp_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_lane_en(req_lane_en), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .slot_count(slot_count)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_slots();
        int total = 0;
        for (int h = 0; h < 2; h++) begin
            int cnt [16];
            int mx = 0;
            for (int b = 0; b < 16; b++) cnt[b] = 0;
            for (int l = 0; l < 16; l++) begin
                if (t_en[h*16 + l]) begin
                    cnt[t_addr[h*16 + l] % 16]++;
                    if (cnt[t_addr[h*16 + l] % 16] > mx) mx = cnt[t_addr[h*16 + l] % 16];
                end
            end
            total += mx;
        end
        return total;
    endfunction

    function automatic logic [WW-1:0] pattern(int a, int salt);
        return 32'hA500_0000 ^ (a * 32'h0101_0101) ^ (salt << 12);
    endfunction

    // Issue the staged request and check latency, slot count and read data.
    task automatic run_req(string tag, bit wr, bit intrude);
        logic [LANES*WW-1:0] prev = rd_data;
        int s = exp_slots();
        int n = 0;
        int bad = 0;
        logic [WW-1:0] act_w = '0;
        logic [WW-1:0] exp_w = '0;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_lane_en = t_en;
        for (int g = 0; g < LANES; g++) begin
            req_addr[g*AW +: AW] = t_addr[g];
            req_wdata[g*WW +: WW] = t_wd[g];
        end
        @(posedge clk);
        forever begin
            @(negedge clk);
            req_valid = 1'b0;
            req_write = 1'b0;
            if (intrude && n == 10) begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_wdata = '1;
            end
            if (done) break;
            @(posedge clk);
            n++;
        end
        check({tag, " R2 latency"}, 64'(n), 64'(2*s));
        check({tag, " R3 R5 slot_count"}, 64'(slot_count), 64'(s));
        if (wr) begin
            for (int g = 0; g < LANES; g++) if (t_en[g]) mdl[t_addr[g]] = t_wd[g];
        end
        for (int g = 0; g < LANES; g++) begin
            logic [WW-1:0] e = (!wr && t_en[g]) ? mdl[t_addr[g]] : prev[g*WW +: WW];
            if (rd_data[g*WW +: WW] !== e && bad == 0) begin
                act_w = rd_data[g*WW +: WW];
                exp_w = e;
                bad++;
            end
        end
        check({tag, " R8 R6 rd_data"}, 64'(act_w), 64'(exp_w));
    endtask

    task automatic clear_stage();
        for (int g = 0; g < LANES; g++) begin
            t_addr[g] = '0;
            t_wd[g] = '0;
        end
        t_en = '0;
    endtask

    task automatic t_reset();
        check("R5 reset slot_count", 64'(slot_count), 64'(0));
        check("R2 reset busy", 64'(busy), 64'(0));
        check("R2 reset done", 64'(done), 64'(0));
    endtask

    // R1: fill all 256 words, 32 consecutive addresses per request.
    task automatic t_fill();
        for (int blk = 0; blk < 8; blk++) begin
            for (int g = 0; g < LANES; g++) begin
                t_addr[g] = 8'(blk*32 + g);
                t_wd[g] = pattern(blk*32 + g, 1);
            end
            t_en = '1;
            run_req("R1 fill", 1'b1, 1'b0);
        end
    endtask

    // R1, R8: linear read, each group covers all banks once.
    task automatic t_read_linear();
        for (int g = 0; g < LANES; g++) t_addr[g] = 8'(g + 96);
        t_en = '1;
        run_req("R1 R8 linear read", 1'b0, 1'b0);
    endtask

    // R3: odd-address stride-two read gives a 2-way conflict per group.
    task automatic t_stride2();
        for (int g = 0; g < LANES; g++) t_addr[g] = 8'(2*g + 1);
        t_en = '1;
        run_req("R3 stride2 read", 1'b0, 1'b0);
    endtask

    // R4: both groups hit the same banks without conflicting with each other.
    task automatic t_halves();
        for (int g = 0; g < 16; g++) begin
            t_addr[g] = 8'(g + 32);
            t_addr[g + 16] = 8'(g + 160);
        end
        t_en = '1;
        run_req("R4 independent groups", 1'b0, 1'b0);
    endtask

    // R3, R9: one address for all lanes; a second request arrives while busy.
    task automatic t_same_addr_busy();
        for (int g = 0; g < LANES; g++) t_addr[g] = 8'd5;
        t_en = '1;
        run_req("R3 R9 same address", 1'b0, 1'b1);
        clear_stage();
        t_addr[0] = 8'd5;
        t_en = 32'h1;
        run_req("R9 memory untouched", 1'b0, 1'b0);
    endtask

    // R6: sparse enables; disabled lanes keep their read words.
    task automatic t_sparse();
        clear_stage();
        t_addr[2] = 8'd3;
        t_addr[7] = 8'd19;
        t_addr[30] = 8'd77;
        t_en = (32'h1 << 2) | (32'h1 << 7) | (32'h1 << 30);
        run_req("R6 sparse", 1'b0, 1'b0);
        clear_stage();
        run_req("R6 empty", 1'b0, 1'b0);
    endtask

    // R7: colliding writes within a group and across groups.
    task automatic t_collide();
        clear_stage();
        t_addr[3] = 8'd200; t_wd[3] = 32'h1111_0003;
        t_addr[9] = 8'd200; t_wd[9] = 32'h2222_0009;
        t_addr[5] = 8'd201; t_wd[5] = 32'h3333_0005;
        t_addr[21] = 8'd201; t_wd[21] = 32'h4444_0021;
        t_en = (32'h1 << 3) | (32'h1 << 9) | (32'h1 << 5) | (32'h1 << 21);
        run_req("R7 collide write", 1'b1, 1'b0);
        clear_stage();
        t_addr[0] = 8'd200;
        t_addr[1] = 8'd201;
        t_en = 32'h3;
        run_req("R7 collide read", 1'b0, 1'b0);
        check("R7 in-group winner", 64'(rd_data[0 +: WW]), 64'(32'h2222_0009));
        check("R7 cross-group winner", 64'(rd_data[WW +: WW]), 64'(32'h4444_0021));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_stage();
        for (int a = 0; a < 256; a++) mdl[a] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_read_linear();
        t_stride2();
        t_halves();
        t_same_addr_busy();
        t_sparse();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule